// File: doc/BRIEF.md
# Instruction Fetch Exception Unit

This unit sits beside the fetch stage of a small processor core. On every valid instruction fetch it inspects the fetch address against a parameterised address map, and it inspects the fetched opcode together with a valid/undefined flag from the opcode decoder. From these it raises one of three synchronous exceptions. The first is a software interrupt, for the break opcode or for a fetch from unpopulated space. The second is an undefined-instruction interrupt. The third is an address trap, raised when code is fetched from the data RAM, the special-function register window or the debug register window.

An address trap does one of two things, chosen by a configuration bit that the watchdog-control logic writes. It can pulse a reset request, or it can raise an address-trap interrupt. The undefined-instruction and address-trap interrupts preempt a non-maskable interrupt service routine that is already running. When that happens an abort pulse tells the core to drop the current process. The accepted cause is latched and presented with a vector request until the core acknowledges it.

Top module: `fetch_exc_unit`

## Requirements
- R1: After reset, exc_req_o, abort_o and rst_req_o are 0 and exc_cause_o is 0 (none). The trap mode is "reset output" (0).
- R2: A valid fetch of opcode 0xFF from program memory sets exc_req_o with exc_cause_o = 1 (software interrupt) on the cycle after the fetch.
- R3: A valid fetch from an address that is neither program memory nor a trapped data region is treated as opcode 0xFF, whatever the opcode and undefined flag: cause 1.
- R4: A valid fetch from program memory with fetch_undef_i = 1 gives exc_cause_o = 2 (undefined instruction).
- R5: A valid fetch from the RAM, SFR or debug-register region with trap mode 0 drives rst_req_o high for exactly one cycle, on the cycle after the fetch, and raises no exc_req_o.
- R6: With trap mode 1, a fetch from a trapped region gives exc_cause_o = 3 (address trap) and no rst_req_o.
- R7: When several causes apply to one fetch, the address trap wins over the undefined instruction, which wins over the software interrupt.
- R8: When an undefined-instruction or address-trap interrupt is accepted while nmi_active_i = 1, abort_o pulses for one cycle together with the new request. A software interrupt, or any cause without nmi_active_i, gives no abort.
- R9: A latched cause holds until ack_i, and fetches in the meantime are ignored. When ack_i is given alone, the request is cleared on the next cycle. When ack_i comes together with a valid fetch, that fetch is evaluated as new.
- R10: trap_cfg_we_i loads trap_cfg_i into the trap mode. A fetch in the same cycle as the write still sees the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Instruction fetch in this cycle |
| fetch_addr_i | input | ADDR_W | Fetch address |
| fetch_opcode_i | input | 8 | Fetched opcode byte |
| fetch_undef_i | input | 1 | Decoder flags opcode as undefined |
| nmi_active_i | input | 1 | Non-maskable interrupt service in progress |
| trap_cfg_we_i | input | 1 | Write strobe for trap mode |
| trap_cfg_i | input | 1 | Trap mode: 0 reset output, 1 interrupt |
| ack_i | input | 1 | Core acknowledges the pending exception |
| exc_req_o | output | 1 | Exception vector request pending |
| exc_cause_o | output | 2 | 0 none, 1 software, 2 undefined, 3 address trap |
| abort_o | output | 1 | Abort the current (NMI) process |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
On every cycle, the assertions check the following. The request and the cause code agree. A pending cause stays frozen until it is acknowledged. Abort and reset pulses appear only together with their legal companions, and only after a fetch. Region decoding, opcode classification, the priority order and the timing of trap-mode writes depend on particular addresses and input combinations. The bench's vector table and directed cases show those.

// File: rtl/fetch_exc_pkg.sv
package fetch_exc_pkg;
  localparam logic [7:0] SWI_OPCODE = 8'hFF;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_SWI   = 2'd1,
    CAUSE_UNDEF = 2'd2,
    CAUSE_ATRAP = 2'd3
  } exc_cause_e;
endpackage

// File: rtl/fetch_region_decode.sv
module fetch_region_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SFR_LO = 16'h0000,
  parameter logic [ADDR_W-1:0] SFR_HI = 16'h003F,
  parameter logic [ADDR_W-1:0] RAM_LO = 16'h0040,
  parameter logic [ADDR_W-1:0] RAM_HI = 16'h023F,
  parameter logic [ADDR_W-1:0] DBR_LO = 16'h0F80,
  parameter logic [ADDR_W-1:0] DBR_HI = 16'h0FFF,
  parameter logic [ADDR_W-1:0] ROM_LO = 16'h8000,
  parameter logic [ADDR_W-1:0] ROM_HI = 16'hFFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_trap_o,
  output logic              in_rom_o
);
  localparam int unsigned N_TRAP = 3;
  localparam logic [N_TRAP-1:0][ADDR_W-1:0] TRAP_LO = {DBR_LO, RAM_LO, SFR_LO};
  localparam logic [N_TRAP-1:0][ADDR_W-1:0] TRAP_HI = {DBR_HI, RAM_HI, SFR_HI};

  logic [N_TRAP-1:0] hit;

  // offset compare avoids constant-range comparisons when a base is zero
  for (genvar g = 0; g < N_TRAP; g++) begin : g_trap
    assign hit[g] = (addr_i - TRAP_LO[g]) <= (TRAP_HI[g] - TRAP_LO[g]);
  end

  assign in_trap_o = |hit;
  assign in_rom_o  = (addr_i - ROM_LO) <= (ROM_HI - ROM_LO);
endmodule

// File: rtl/fetch_exc_prio.sv
module fetch_exc_prio
  import fetch_exc_pkg::*;
(
  input  logic       valid_i,
  input  logic       in_trap_i,
  input  logic       in_rom_i,
  input  logic [7:0] opcode_i,
  input  logic       undef_i,
  output exc_cause_e cause_o
);
  always_comb begin
    cause_o = CAUSE_NONE;
    if (valid_i) begin
      if (in_trap_i)                   cause_o = CAUSE_ATRAP;
      else if (!in_rom_i)              cause_o = CAUSE_SWI;   // unpopulated space reads 0xFF
      else if (undef_i)                cause_o = CAUSE_UNDEF;
      else if (opcode_i == SWI_OPCODE) cause_o = CAUSE_SWI;
    end
  end
endmodule

// File: rtl/fetch_exc_state.sv
module fetch_exc_state
  import fetch_exc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  exc_cause_e evt_i,
  input  logic       nmi_active_i,
  input  logic       cfg_we_i,
  input  logic       cfg_i,
  input  logic       ack_i,
  output logic       req_o,
  output exc_cause_e cause_o,
  output logic       abort_o,
  output logic       rst_req_o
);
  logic       pend_q, abort_q, rst_q, trap_int_q;
  exc_cause_e cause_q;
  logic       take;

  assign take = (!pend_q || ack_i) && (evt_i != CAUSE_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      cause_q    <= CAUSE_NONE;
      abort_q    <= 1'b0;
      rst_q      <= 1'b0;
      trap_int_q <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      rst_q   <= 1'b0;
      if (cfg_we_i) trap_int_q <= cfg_i;
      if (ack_i) begin
        pend_q  <= 1'b0;
        cause_q <= CAUSE_NONE;
      end
      if (take) begin
        if (evt_i == CAUSE_ATRAP && !trap_int_q) begin
          rst_q <= 1'b1;
        end else begin
          pend_q  <= 1'b1;
          cause_q <= evt_i;
          abort_q <= nmi_active_i && (evt_i != CAUSE_SWI);
        end
      end
    end
  end

  assign req_o     = pend_q;
  assign cause_o   = cause_q;
  assign abort_o   = abort_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/fetch_exc_unit.sv
module fetch_exc_unit
  import fetch_exc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SFR_LO = 16'h0000,
  parameter logic [ADDR_W-1:0] SFR_HI = 16'h003F,
  parameter logic [ADDR_W-1:0] RAM_LO = 16'h0040,
  parameter logic [ADDR_W-1:0] RAM_HI = 16'h023F,
  parameter logic [ADDR_W-1:0] DBR_LO = 16'h0F80,
  parameter logic [ADDR_W-1:0] DBR_HI = 16'h0FFF,
  parameter logic [ADDR_W-1:0] ROM_LO = 16'h8000,
  parameter logic [ADDR_W-1:0] ROM_HI = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [7:0]        fetch_opcode_i,
  input  logic              fetch_undef_i,
  input  logic              nmi_active_i,
  input  logic              trap_cfg_we_i,
  input  logic              trap_cfg_i,
  input  logic              ack_i,
  output logic              exc_req_o,
  output logic [1:0]        exc_cause_o,
  output logic              abort_o,
  output logic              rst_req_o
);
  logic       in_trap, in_rom;
  exc_cause_e evt, cause;

  fetch_region_decode #(
    .ADDR_W(ADDR_W),
    .SFR_LO(SFR_LO), .SFR_HI(SFR_HI),
    .RAM_LO(RAM_LO), .RAM_HI(RAM_HI),
    .DBR_LO(DBR_LO), .DBR_HI(DBR_HI),
    .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)
  ) i_decode (
    .addr_i   (fetch_addr_i),
    .in_trap_o(in_trap),
    .in_rom_o (in_rom)
  );

  fetch_exc_prio i_prio (
    .valid_i  (fetch_valid_i),
    .in_trap_i(in_trap),
    .in_rom_i (in_rom),
    .opcode_i (fetch_opcode_i),
    .undef_i  (fetch_undef_i),
    .cause_o  (evt)
  );

  fetch_exc_state i_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .nmi_active_i(nmi_active_i),
    .cfg_we_i    (trap_cfg_we_i),
    .cfg_i       (trap_cfg_i),
    .ack_i       (ack_i),
    .req_o       (exc_req_o),
    .cause_o     (cause),
    .abort_o     (abort_o),
    .rst_req_o   (rst_req_o)
  );

  assign exc_cause_o = cause;
endmodule

// File: rtl/fetch_exc_checker.sv
module fetch_exc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fetch_valid_i,
  input logic       ack_i,
  input logic       exc_req_o,
  input logic [1:0] exc_cause_o,
  input logic       abort_o,
  input logic       rst_req_o
);
  assert_req_has_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o == (exc_cause_o != 2'd0));

  assert_hold_until_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_o && !ack_i) |=> (exc_req_o && $stable(exc_cause_o)));

  assert_idle_stays_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_req_o && !fetch_valid_i) |=> (!exc_req_o && !rst_req_o));

  assert_abort_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (exc_req_o && exc_cause_o[1]));

  assert_abort_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !ack_i) |=> !abort_o);

  assert_rst_after_fetch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> ($past(fetch_valid_i) && !abort_o));
endmodule

bind fetch_exc_unit fetch_exc_checker i_fetch_exc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_valid_i(fetch_valid_i),
  .ack_i        (ack_i),
  .exc_req_o    (exc_req_o),
  .exc_cause_o  (exc_cause_o),
  .abort_o      (abort_o),
  .rst_req_o    (rst_req_o)
);

// File: tb/test_fetch_exc_unit.sv
module test_fetch_exc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 14;

  typedef struct packed {
    logic [7:0]  req_id;
    logic        mode;
    logic [15:0] addr;
    logic [7:0]  op;
    logic        undef;
    logic        nmi;
    logic [1:0]  cause;
    logic        abort;
    logic        rst;
  } vec_t;

  // cause: 0 none, 1 swi, 2 undef, 3 atrap; mode 0 reset, 1 interrupt
  localparam vec_t VECS [N_VEC] = '{
    '{8'd2,  1'b0, 16'h8000, 8'hFF, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0}, // R2
    '{8'd2,  1'b0, 16'h8000, 8'h12, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R2 normal opcode
    '{8'd3,  1'b0, 16'h1000, 8'h00, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0}, // R3
    '{8'd3,  1'b0, 16'h0240, 8'h12, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0}, // R3
    '{8'd4,  1'b0, 16'h9000, 8'h37, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0}, // R4
    '{8'd8,  1'b0, 16'h9000, 8'h37, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0}, // R8
    '{8'd5,  1'b0, 16'h0040, 8'h12, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1}, // R5 RAM
    '{8'd5,  1'b0, 16'h0000, 8'hFF, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1}, // R5 SFR
    '{8'd6,  1'b1, 16'h0F80, 8'h00, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0}, // R6 DBR
    '{8'd8,  1'b1, 16'h023F, 8'h00, 1'b0, 1'b1, 2'd3, 1'b1, 1'b0}, // R8
    '{8'd7,  1'b1, 16'h003F, 8'hFF, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0}, // R7
    '{8'd7,  1'b0, 16'hFFFF, 8'hFF, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0}, // R7
    '{8'd8,  1'b0, 16'h8000, 8'hFF, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0}, // R8 swi no abort
    '{8'd5,  1'b0, 16'h0FFF, 8'h00, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1}  // R5 DBR
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic fv = 1'b0, undef = 1'b0, nmi = 1'b0, cwe = 1'b0, cfg = 1'b0, ack = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  op = '0;
  logic        req, abort, rreq;
  logic [1:0]  cause;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_exc_unit i_fetch_exc_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fv), .fetch_addr_i(addr), .fetch_opcode_i(op),
    .fetch_undef_i(undef), .nmi_active_i(nmi),
    .trap_cfg_we_i(cwe), .trap_cfg_i(cfg), .ack_i(ack),
    .exc_req_o(req), .exc_cause_o(cause), .abort_o(abort), .rst_req_o(rreq)
  );

  task automatic cyc(input logic v, input logic [15:0] a, input logic [7:0] o,
                     input logic u, input logic n, input logic we, input logic c,
                     input logic k);
    @(negedge clk);
    fv = v; addr = a; op = o; undef = u; nmi = n; cwe = we; cfg = c; ack = k;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic chk(input string tag, input logic [1:0] ec, input logic er,
                     input logic ea, input logic rr);
    n_chk++;
    if (cause !== ec || req !== er || abort !== ea || rreq !== rr) begin
      n_fail++;
      $display("FAIL %s: req/cause/abort/rst = %b/%0d/%b/%b expected %b/%0d/%b/%b",
               tag, req, cause, abort, rreq, er, ec, ea, rr);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset", 2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle();
    chk("R1 after reset", 2'd0, 1'b0, 1'b0, 1'b0);

    // R1: trap mode resets to reset output
    cyc(1'b1, 16'h0100, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 default trap mode", 2'd0, 1'b0, 1'b0, 1'b1);
    idle();
    chk("R5 pulse single cycle", 2'd0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < N_VEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req_id, i);
      cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 1'b1, VECS[i].mode, 1'b0);
      cyc(1'b1, VECS[i].addr, VECS[i].op, VECS[i].undef, VECS[i].nmi, 1'b0, 1'b0, 1'b0);
      chk(tag, VECS[i].cause, VECS[i].cause != 2'd0, VECS[i].abort, VECS[i].rst);
      idle();
      chk({tag, " hold"}, VECS[i].cause, VECS[i].cause != 2'd0, 1'b0, 1'b0);
      cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk({tag, " ack"}, 2'd0, 1'b0, 1'b0, 1'b0);
    end

    // R9: fetches while pending are ignored
    cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b1, 16'h8000, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 swi taken", 2'd1, 1'b1, 1'b0, 1'b0);
    cyc(1'b1, 16'h0040, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 trap ignored while pending", 2'd1, 1'b1, 1'b0, 1'b0);
    // R9: ack with a fetch evaluates the new fetch
    cyc(1'b1, 16'h8800, 8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R9 ack plus fetch", 2'd2, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 ack clears", 2'd0, 1'b0, 1'b0, 1'b0);

    // R10: write in same cycle as trap fetch uses old mode (1 -> interrupt)
    cyc(1'b1, 16'h0F90, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 old mode interrupt", 2'd3, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 16'h0F90, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 new mode reset", 2'd0, 1'b0, 1'b0, 1'b1);
    idle();
    chk("R10 idle", 2'd0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule